// File: doc/BRIEF.md
# Six-Digit Multiplexed Display Scanner

The scanner walks a multiplexed numeric display one digit at a time, from the most significant position to the least significant. A storage latch sits between the value being counted and the display. While the hold control is low, the latch follows the incoming digit word. While the hold control is high, the latch freezes, and the frozen value is what the display shows. A Johnson ring of half as many flip-flops as there are digits selects the active position. For that position the scanner drives a one-hot digit strobe, the raw BCD code and an active-high seven-segment pattern.

Every advance of the scan starts a dark gap of a programmable number of system clocks. During the gap the strobes and the segments are all off. The BCD output moves to the new digit on the same edge that opens the gap, so it has settled before the strobe rises. Holding the scan-reset input low parks the scan on the most significant digit and turns the segments off. Leading-zero suppression hides zero digits above the first nonzero one, and it acts on the segment pins only.

Top module: `dscan_top`

## Requirements
- R1: While `store` is low, the latch captures `cnt_digits` on every clock edge. A new word therefore appears on `bcd_out` for the selected digit one clock after it is driven.
- R2: While `store` is high, the latch keeps its contents whatever `cnt_digits` does. Every digit the scan visits shows the held value.
- R3: After reset the latch is all zero and the scan sits on the most significant digit. No gap is running, so `strobe` equals the MSD bit alone and `bcd_out` is 0.
- R4: Each `scan_pulse` sampled with `set_n` high moves the scan one position toward the least significant digit. From the LSD it wraps to the MSD. `strobe[NUM_DIGITS-1]` is the MSD and `strobe[0]` is the LSD. In `cnt_digits`, the MSD is the top nibble. At most one strobe is ever high.
- R5: After an accepted scan pulse, `strobe` and `seg` stay all zero for exactly `BLANK_CYCLES` clocks. The new digit's strobe then comes on.
- R6: `bcd_out` presents the new digit's code from the first clock of the gap onward.
- R7: While `set_n` is low, the scan is forced to the MSD and `scan_pulse` is ignored. Any running gap is cancelled, `seg` is all zero, the MSD strobe is on and `bcd_out` shows the MSD code. After release, the next pulse selects the second digit.
- R8: `seg` is {g,f,e,d,c,b,a} with a on bit 0, active high. Codes 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F hex. Codes 10 to 15 give 00.
- R9: With `lzb_off` low, a digit whose code and all more-significant codes are zero has `seg` 00, except the LSD, which is always shown. Codes 10 to 15 count as nonzero. `bcd_out` is never suppressed.
- R10: With `lzb_off` high, zero digits in leading positions display the pattern for 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_pulse | input | 1 | One-clock request to advance the scan |
| store | input | 1 | High holds the display latch, low lets it follow |
| set_n | input | 1 | Low forces the scan to the MSD and darkens the segments |
| lzb_off | input | 1 | High disables leading-zero suppression |
| cnt_digits | input | NUM_DIGITS*4 (24) | BCD digits to display, MSD in the top nibble |
| strobe | output | NUM_DIGITS (6) | One-hot digit select, bit NUM_DIGITS-1 is the MSD |
| bcd_out | output | 4 | BCD code of the selected digit |
| seg | output | 7 | Segments {g,f,e,d,c,b,a}, active high |

## Verification
Some properties are checked on every clock:
- the strobes are one-hot or idle;
- the Johnson ring only ever holds a legal pattern, steps by exactly one position per accepted pulse and parks while scan-reset is held;
- the latch stays put while held;
- the gap that follows an accepted pulse is dark;
- the least significant digit is never suppressed.

Other behaviour only the bench's scenarios can show:
- the exact segment pattern for each code;
- which leading positions go dark for a given word, and the effect of the suppression disable;
- the length of the gap in clocks;
- the one-clock latency from the digit word to the BCD output.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

   localparam int BCD_W = 4;
   localparam int SEG_W = 7;

   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0] seg_t;

endpackage

// File: rtl/dscan_latch.sv
module dscan_latch #(
   parameter int WIDTH = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             store,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (!store) q <= d;
   end

   // R2: a held latch never moves
   assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(store) && $past(rst_n) |-> $stable(q));

endmodule

// File: rtl/dscan_johnson.sv
module dscan_johnson #(
   parameter int NUM_DIGITS = 6,
   localparam int JW    = NUM_DIGITS / 2,
   localparam int IDX_W = $clog2(NUM_DIGITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             force_msd,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DIGITS - 1);

   logic [JW-1:0] ring_q;

   always_ff @(posedge clk) begin
      if (!rst_n || force_msd) ring_q <= '0;
      else if (advance)        ring_q <= {ring_q[JW-2:0], ~ring_q[JW-1]};
   end

   // position = ones count while filling, NUM_DIGITS - ones while draining
   always_comb begin
      if (ring_q[JW-1]) idx = IDX_W'(NUM_DIGITS - $countones(ring_q));
      else              idx = IDX_W'($countones(ring_q));
   end

   // R4: only patterns with a single boundary between ones and zeros
   assert_ring_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ring_q[JW-2:0] ^ ring_q[JW-1:1]) <= 1);

   // R4: one step per accepted advance, wrapping at the last digit
   assert_ring_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(advance) && !$past(force_msd) |->
         idx == (($past(idx) == LAST) ? '0 : $past(idx) + 1'b1));

   // R7: scan-reset parks the ring on the MSD
   assert_ring_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(force_msd) |-> idx == '0);

endmodule

// File: rtl/dscan_blank_timer.sv
module dscan_blank_timer #(
   parameter int BLANK_CYCLES = 4,
   localparam int CW = $clog2(BLANK_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cancel,
   output logic blank
);

   localparam logic [CW-1:0] LOAD = CW'(BLANK_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || cancel)  cnt_q <= '0;
      else if (start)        cnt_q <= LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign blank = (cnt_q != '0);

   // R5: a gap never outlasts its programmed length
   assert_gap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);

endmodule

// File: rtl/dscan_seg_decode.sv
module dscan_seg_decode
   import dscan_pkg::*;
(
   input  bcd_t code,
   output seg_t seg
);

   always_comb begin
      unique case (code)
         4'd0:    seg = 7'h3F;
         4'd1:    seg = 7'h06;
         4'd2:    seg = 7'h5B;
         4'd3:    seg = 7'h4F;
         4'd4:    seg = 7'h66;
         4'd5:    seg = 7'h6D;
         4'd6:    seg = 7'h7D;
         4'd7:    seg = 7'h07;
         4'd8:    seg = 7'h7F;
         4'd9:    seg = 7'h6F;
         default: seg = 7'h00;
      endcase
   end

endmodule

// File: rtl/dscan_top.sv
module dscan_top
   import dscan_pkg::*;
#(
   parameter int NUM_DIGITS   = 6,
   parameter int BLANK_CYCLES = 4,
   localparam int DATA_W = NUM_DIGITS * BCD_W,
   localparam int IDX_W  = $clog2(NUM_DIGITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_pulse,
   input  logic              store,
   input  logic              set_n,
   input  logic              lzb_off,
   input  logic [DATA_W-1:0] cnt_digits,
   output logic [NUM_DIGITS-1:0] strobe,
   output logic [BCD_W-1:0]  bcd_out,
   output logic [SEG_W-1:0]  seg
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DIGITS - 1);

   if (NUM_DIGITS < 4 || (NUM_DIGITS % 2) != 0) begin : g_bad_digits
      $error("NUM_DIGITS must be even and at least 4");
   end
   if (BLANK_CYCLES < 0) begin : g_bad_blank
      $error("BLANK_CYCLES must not be negative");
   end

   logic [DATA_W-1:0] held;
   logic [IDX_W-1:0]  idx;
   logic              blank;
   logic              advance;
   bcd_t              dig [NUM_DIGITS];
   logic [NUM_DIGITS-1:0] zero_pfx;
   seg_t              seg_raw;
   logic              lz_hide;

   assign advance = scan_pulse && set_n;

   dscan_latch #(.WIDTH(DATA_W)) latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .store (store),
      .d     (cnt_digits),
      .q     (held)
   );

   dscan_johnson #(.NUM_DIGITS(NUM_DIGITS)) ring_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .force_msd (!set_n),
      .idx       (idx)
   );

   if (BLANK_CYCLES > 0) begin : g_gap
      dscan_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) gap_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (advance),
         .cancel (!set_n),
         .blank  (blank)
      );

      // R5: the clock after an accepted pulse is dark
      assert_gap_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(advance) |-> strobe == '0 && seg == '0);
   end else begin : g_no_gap
      assign blank = 1'b0;
   end

   // position 0 is the MSD, taken from the top nibble
   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
      assign dig[i] = held[(NUM_DIGITS-1-i)*BCD_W +: BCD_W];
      if (i == 0) begin : g_first
         assign zero_pfx[i] = (dig[i] == '0);
      end else begin : g_rest
         assign zero_pfx[i] = zero_pfx[i-1] && (dig[i] == '0);
      end
   end

   assign bcd_out = dig[idx];

   dscan_seg_decode dec_i (
      .code (bcd_out),
      .seg  (seg_raw)
   );

   assign lz_hide = !lzb_off && (idx != LAST) && zero_pfx[idx];

   always_comb begin
      strobe = '0;
      if (!blank) strobe[NUM_DIGITS-1-idx] = 1'b1;
   end

   assign seg = (blank || !set_n || lz_hide) ? '0 : seg_raw;

   // R4: never more than one digit selected
   assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobe));

   // R7: with scan-reset held, only the MSD strobe is on
   assert_park_msd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !set_n && $past(!set_n) |->
         strobe == {1'b1, {(NUM_DIGITS-1){1'b0}}});

   // R9: the LSD with a valid code is always lit
   assert_lsd_lit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_n && strobe[0] && bcd_out < 4'd10 |-> seg != '0);

endmodule

// File: tb/dscan_top_tb_top.sv
module dscan_top_tb_top;

   localparam int ND = 6;
   localparam int BC = 4;

   typedef struct packed {
      logic [23:0] val;
      logic        lzb;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{val: 24'h012345, lzb: 1'b0},
      '{val: 24'h000007, lzb: 1'b0},
      '{val: 24'h000000, lzb: 1'b0},
      '{val: 24'h000000, lzb: 1'b1},
      '{val: 24'h00A030, lzb: 1'b0},
      '{val: 24'h987654, lzb: 1'b1},
      '{val: 24'h100000, lzb: 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_pulse = 1'b0;
   logic        store = 1'b0;
   logic        set_n = 1'b1;
   logic        lzb_off = 1'b0;
   logic [23:0] cnt_digits = '0;
   logic [5:0]  strobe;
   logic [3:0]  bcd_out;
   logic [6:0]  seg;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   dscan_top #(.NUM_DIGITS(ND), .BLANK_CYCLES(BC)) dut_i (
      .clk(clk), .rst_n(rst_n), .scan_pulse(scan_pulse), .store(store),
      .set_n(set_n), .lzb_off(lzb_off), .cnt_digits(cnt_digits),
      .strobe(strobe), .bcd_out(bcd_out), .seg(seg)
   );

   function automatic logic [6:0] exp_seg(input logic [3:0] c);
      case (c)
         4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
         4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
         4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
         4'd9: return 7'h6F;  default: return 7'h00;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse();
      scan_pulse = 1'b1;
      @(negedge clk);
      scan_pulse = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 strobe", strobe, 6'b100000);
      chk("R3 bcd", bcd_out, 0);

      // vector table: each word walked across all six positions
      foreach (VECS[v]) begin
         cnt_digits = VECS[v].val;
         lzb_off    = VECS[v].lzb;
         store      = 1'b0;
         set_n      = 1'b0;
         @(negedge clk);
         chk("R7 park strobe", strobe, 6'b100000);
         chk("R7 park seg", seg, 0);
         chk("R7 park bcd", bcd_out, VECS[v].val[23:20]);
         set_n = 1'b1;
         @(negedge clk);
         for (int d = 0; d < ND; d++) begin
            logic [3:0] code;
            logic       zp;
            logic [6:0] es;
            if (d > 0) begin
               pulse();
               if (d == 1) begin
                  chk("R5 gap strobe", strobe, 0);
                  chk("R6 bcd early", bcd_out, VECS[v].val[19:16]);
               end
               repeat (BC) @(negedge clk);
            end
            code = VECS[v].val[(ND-1-d)*4 +: 4];
            zp = 1'b1;
            for (int k = 0; k <= d; k++) if (VECS[v].val[(ND-1-k)*4 +: 4] != 0) zp = 1'b0;
            es = (!VECS[v].lzb && d != ND-1 && zp) ? 7'h00 : exp_seg(code);
            chk("R4 strobe", strobe, 6'b100000 >> d);
            chk("R9 bcd", bcd_out, code);
            chk(VECS[v].lzb ? "R10 seg" : "R9 seg", seg, es);
         end
      end

      // R4 wrap from LSD to MSD
      pulse();
      repeat (BC) @(negedge clk);
      chk("R4 wrap", strobe, 6'b100000);

      // R5 exact gap length
      pulse();
      repeat (BC-1) @(negedge clk);
      chk("R5 still dark", strobe, 0);
      chk("R5 seg dark", seg, 0);
      @(negedge clk);
      chk("R5 lit", strobe, 6'b010000);

      // R1 latency and R2 hold
      lzb_off = 1'b1;
      set_n = 1'b0;
      cnt_digits = 24'h123456;
      @(negedge clk);
      set_n = 1'b1;
      @(negedge clk);
      chk("R1 follow", bcd_out, 1);
      store = 1'b1;
      cnt_digits = 24'h999999;
      repeat (2) @(negedge clk);
      chk("R2 hold msd", bcd_out, 1);
      pulse();
      repeat (BC) @(negedge clk);
      chk("R2 hold next", bcd_out, 2);
      store = 1'b0;
      chk("R1 before edge", bcd_out, 2);
      @(negedge clk);
      chk("R1 one clock", bcd_out, 9);

      // R7 pulses ignored while parked, then resume at second digit
      set_n = 1'b0;
      @(negedge clk);
      pulse();
      chk("R7 ignore strobe", strobe, 6'b100000);
      chk("R7 ignore bcd", bcd_out, 9);
      set_n = 1'b1;
      @(negedge clk);
      pulse();
      repeat (BC) @(negedge clk);
      chk("R7 resume", strobe, 6'b010000);

      // R8 every code on the MSD with suppression off
      set_n = 1'b0;
      @(negedge clk);
      set_n = 1'b1;
      for (int c = 0; c < 16; c++) begin
         cnt_digits = {4'(c), 20'h0};
         @(negedge clk);
         chk("R8 decode", seg, exp_seg(4'(c)));
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule